// File: doc/BRIEF.md
# I2C Register-Access Slave

This block connects an external I2C bus to a byte-wide register file inside the chip. SCL and SDA are sampled by the fast system clock through synchronizer chains. The block recognises START, repeated START and STOP conditions from the sampled lines. It compares the first byte against its 7-bit device address and then acts as the bus target. On the bus, SDA is handled as open drain: the block only produces a drive-low enable.

A write transaction carries a register pointer followed by any number of data bytes. Each data byte goes out on a one-cycle write strobe to the register-file port. A read needs a short write phase that only sets the pointer, followed by a repeated START with the read direction. Register bytes are then shifted out until the host declines one with a NACK. The pointer steps after every data byte in both directions. A separate active-low bus reset input keeps SDA undriven while it is low.

Top module: `i2c_regs_slave`

## Requirements
- R1: After the synchronous system reset, `sda_oe` and `reg_we` are both low.
- R2: A first byte whose upper seven bits equal the device address (default 0x60) is acknowledged by holding `sda_oe` high through the ninth SCL pulse. The lowest bit of that byte selects write (0) or read (1).
- R3: When the address does not match, the block gives no acknowledge. It issues no write and does not drive SDA for the rest of that transfer, until the next START or STOP.
- R4: In a write, the byte after the address loads the register pointer. Every later byte is received MSB first and acknowledged. Each such byte produces exactly one single-cycle `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: The pointer increases by one, modulo 2^ADDR_W, after every data byte written or read. A pointer of 0xFF therefore moves on to 0x00.
- R6: After a repeated START with the read bit set, the block returns the register at the pointer on SDA, MSB first. A low bit means `sda_oe` is high. Further bytes follow for as long as the host acknowledges.
- R7: A host NACK after a read byte ends the read. `sda_oe` is released at the end of that ninth pulse and stays low until the next START.
- R8: While `bus_rst_n` is low, `sda_oe` is never high, even when the block is addressed. The transfer still advances internally, so data bytes are still written.
- R9: A START or STOP that arrives partway through a byte discards that byte, and no write results. A repeated START then begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_rst_n | input | 1 | Active-low bus reset; low blocks all SDA driving |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Drive-low enable for the SDA pad |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_addr | output | ADDR_W | Register address (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr`, combinational |

## Verification
A change on SCL reaches the control logic after three system clock edges: two synchronizer stages, then the edge register and the state register. That means `sda_oe` follows an SCL falling edge about three cycles later, and `reg_we` fires about three cycles after the falling edge that ends the eighth bit of a data byte. The bench waits 20 system clocks between every bus edge and samples SDA in the middle of the SCL-high phase, well after any response is due. Register writes are matched by a monitor that takes the expected address and data from a queue whenever `reg_we` is seen. The check is therefore independent of the exact cycle, and any write that arrives without a queued entry is reported as a failure.

// File: rtl/i2c_regs_pkg.sv
// Shared types for the I2C register-access slave.
// Assumes: bytes on the bus are always eight bits wide.
package i2c_regs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for START
        ST_RX,     // shifting a byte in from the host
        ST_ACK,    // holding SDA low for the acknowledge pulse
        ST_TX,     // shifting a register byte out
        ST_MACK    // host acknowledge slot after a sent byte
    } bus_state_t;

    typedef enum logic [1:0] {
        BK_DEV,    // device address plus direction
        BK_PTR,    // register pointer
        BK_DATA    // register data
    } byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Multi-flop synchronizer for one bus line.
// Assumes: STAGES >= 2; the reset value matches an idle (high) line.
module i2c_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
// Detects SCL edges and START / STOP conditions from synchronized lines.
// Assumes: inputs are already synchronized to clk.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_d, sda_d;

    // Keep the previous sampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
// Byte framing, acknowledge and transaction flow of the I2C slave.
// Assumes: strobes come from i2c_cond_detect; reg_rdata is combinational
// on reg_addr; drive_low is gated by the bus reset outside this module.
module i2c_slave_fsm
    import i2c_regs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter int         ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              drive_low,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    bus_state_t        st;
    byte_kind_t        kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, tx_next;
    logic [ADDR_W-1:0] ptr;
    logic              rw, mack;

    assign tx_next  = {tx_sh[BYTE_W-2:0], 1'b0};
    assign reg_addr = ptr;

    // Main sequencer: framing, address match, pointer and data movement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= BK_DEV;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            drive_low <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (reg_we) ptr <= ptr + 1'b1;
            if (start_c) begin
                st        <= ST_RX;
                kind      <= BK_DEV;
                cnt       <= '0;
                drive_low <= 1'b0;
            end else if (stop_c) begin
                st        <= ST_IDLE;
                drive_low <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && cnt != FULL) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            case (kind)
                                BK_DEV: begin
                                    if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                                        rw        <= rx_sh[0];
                                        st        <= ST_ACK;
                                        drive_low <= 1'b1;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                BK_PTR: begin
                                    ptr       <= ADDR_W'(rx_sh);
                                    st        <= ST_ACK;
                                    drive_low <= 1'b1;
                                end
                                default: begin
                                    reg_wdata <= rx_sh;
                                    reg_we    <= 1'b1;
                                    st        <= ST_ACK;
                                    drive_low <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx_sh     <= reg_rdata;
                                ptr       <= ptr + 1'b1;
                                drive_low <= ~reg_rdata[BYTE_W-1];
                                st        <= ST_TX;
                            end else begin
                                drive_low <= 1'b0;
                                st        <= ST_RX;
                                kind      <= (kind == BK_DEV) ? BK_PTR : BK_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                drive_low <= 1'b0;
                                st        <= ST_MACK;
                            end else begin
                                tx_sh     <= tx_next;
                                drive_low <= ~tx_next[BYTE_W-1];
                                cnt       <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                tx_sh     <= reg_rdata;
                                ptr       <= ptr + 1'b1;
                                drive_low <= ~reg_rdata[BYTE_W-1];
                                st        <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    ack_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK) |-> drive_low);

    // R3 R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_RX) |-> !drive_low);

    // R4
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

    // R6
    tx_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && $past(st) == ST_TX && scl_lvl && $past(scl_lvl))
        |-> $stable(drive_low));
endmodule

// File: rtl/i2c_regs_slave.sv
// Top level: I2C slave giving a host byte access to a register file.
// Assumes: clk is at least ~10x the SCL rate; register file answers
// reg_rdata combinationally from reg_addr; pad is open drain.
module i2c_regs_slave
    import i2c_regs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, sync_lines;
    logic scl_rise, scl_fall, start_c, stop_c, drive_low;

    assign raw_lines = {sda_i, scl_i};

    // One synchronizer chain per bus line.
    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_sync
            i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (raw_lines[i]),
                .q    (sync_lines[i])
            );
        end
    endgenerate

    i2c_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (sync_lines[0]),
        .sda_s   (sync_lines[1]),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_c (start_c),
        .stop_c  (stop_c)
    );

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .scl_lvl  (sync_lines[0]),
        .sda_lvl  (sync_lines[1]),
        .reg_rdata(reg_rdata),
        .drive_low(drive_low),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata)
    );

    // Bus reset overrides every drive request from the sequencer.
    assign sda_oe = drive_low & bus_rst_n;
endmodule

// File: tb/test_i2c_regs_slave.sv
module test_i2c_regs_slave;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_n = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line, sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] regs [0:255];

    int checks = 0;
    int errors = 0;
    int drive_in_reset = 0;
    int cycles = 0;
    logic [15:0] exp_wr [$];

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_regs_slave i_i2c_regs_slave (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    initial for (int i = 0; i < 256; i++) regs[i] = 8'(i * 7 + 3);

    // Register file model behind the port.
    always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each write strobe against the scoreboard queue (R4).
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R4/R3/R9 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = exp_wr.pop_front();
                check({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
        if (!bus_rst_n && sda_oe) drive_in_reset++;
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw();
    endtask

    task automatic bit_cycle(input logic b, output logic seen);
        m_sda = b; qw(); scl = 1'b1; qw(); seen = sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            d[i] = s;
        end
        bit_cycle(nack, s);
    endtask

    // Driver: write burst, pushing expected writes to the scoreboard.
    task automatic write_burst(input logic [7:0] ptr, input logic [7:0] d [], input string req);
        logic ack;
        do_start();
        wr_byte(8'hC0, ack); check(ack, "R2 address ack", ack, 1);
        wr_byte(ptr, ack);   check(ack, req, ack, 1);
        foreach (d[i]) begin
            exp_wr.push_back({8'(ptr + i), d[i]});
            wr_byte(d[i], ack); check(ack, "R4 data ack", ack, 1);
        end
        do_stop();
    endtask

    task automatic read_burst(input logic [7:0] ptr, input int n, input string req);
        logic ack;
        logic [7:0] d;
        do_start();
        wr_byte(8'hC0, ack); check(ack, "R2 address ack", ack, 1);
        wr_byte(ptr, ack);   check(ack, "R6 pointer ack", ack, 1);
        do_start();
        wr_byte(8'hC1, ack); check(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = regs[8'(ptr + i)];
            rd_byte(i == n - 1, d);
            check(d == e, req, d, e);
        end
        check(!sda_oe, "R7 released after NACK", sda_oe, 0);
        qw();
        check(!sda_oe, "R7 stays released", sda_oe, 0);
        do_stop();
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog expired", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (4) @(negedge clk);
        check(!sda_oe, "R1 sda_oe after reset", sda_oe, 0);
        check(!reg_we, "R1 reg_we after reset", reg_we, 0);
        rst_n = 1'b1;
        qw();

        // R4 R5: multi-byte write.
        write_burst(8'h10, '{8'hA5, 8'h3C, 8'h81}, "R4 pointer ack");
        // R6 R5: read back with auto-increment, NACK at the end (R7).
        read_burst(8'h10, 3, "R6 read data MSB first");
        // R5: pointer wraps from 0xFF to 0x00.
        write_burst(8'hFF, '{8'h12, 8'hE7}, "R5 pointer ack at top");
        read_burst(8'hFF, 2, "R5 read across wrap");

        // R3: wrong address, no ack, no writes, no drive.
        do_start();
        wr_byte(8'hA0, ack); check(!ack, "R3 no ack on mismatch", ack, 0);
        wr_byte(8'h05, ack); check(!ack, "R3 ignored pointer byte", ack, 0);
        wr_byte(8'h77, ack); check(!ack, "R3 ignored data byte", ack, 0);
        do_stop();
        do_start();
        wr_byte(8'hC3, ack); check(!ack, "R3 no ack on mismatch read", ack, 0);
        rd_byte(1'b1, d);    check(d == 8'hFF, "R3 no read data driven", d, 8'hFF);
        do_stop();

        // R8: bus reset low blocks all driving but writes still land.
        bus_rst_n = 1'b0;
        do_start();
        wr_byte(8'hC0, ack); check(!ack, "R8 ack suppressed", ack, 0);
        wr_byte(8'h20, ack); check(!ack, "R8 pointer ack suppressed", ack, 0);
        exp_wr.push_back({8'h20, 8'h5A});
        wr_byte(8'h5A, ack); check(!ack, "R8 data ack suppressed", ack, 0);
        do_stop();
        do_start();
        wr_byte(8'hC0, ack);
        wr_byte(8'h20, ack);
        do_start();
        wr_byte(8'hC1, ack);
        rd_byte(1'b1, d); check(d == 8'hFF, "R8 read data suppressed", d, 8'hFF);
        do_stop();
        bus_rst_n = 1'b1;
        check(drive_in_reset == 0, "R8 drive while bus reset", drive_in_reset, 0);
        read_burst(8'h20, 1, "R8 write landed during bus reset");

        // R9: STOP in mid byte discards it.
        do_start();
        wr_byte(8'hC0, ack);
        wr_byte(8'h30, ack);
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, ack);
        do_stop();
        read_burst(8'h30, 1, "R9 STOP abort left register intact");

        // R9: repeated START in mid byte begins a new address phase.
        do_start();
        wr_byte(8'hC0, ack);
        wr_byte(8'h31, ack);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, ack);
        do_start();
        wr_byte(8'hC1, ack); check(ack, "R9 address after aborted byte", ack, 1);
        rd_byte(1'b1, d);    check(d == regs[8'h31], "R9 read after START abort", d, regs[8'h31]);
        do_stop();

        qw();
        check(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule